// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge is one 64-bit, directly addressed control word that opens a window onto a larger indirect register space. A host writes the whole word in a single transfer. That word carries the command bit, a 20-bit indirect address and a 16-bit data field. The write starts one indirect access. On the next clock the bridge carries out the access and reports its outcome in a status byte of the same word. The host can read the word back at any time.

Bits are numbered from the most significant end: field bit 0 is Verilog bit 63, and field bit 63 is Verilog bit 0. The command bit (bit 0, `[63]`) chooses the operation. A value of 0 stores the data field at the indirect address. A value of 1 fetches 16 bits from that address into the data field.

The indirect space is a local register file of `ENTRIES` words, indexed by the low address bits. It sits in block RAM, and a per-entry valid flag makes it read as cleared after reset. Two debug outputs hold the last address and the last data word moved.

Top module: `ind_reg_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, the control word, `busy`, `dbg_addr` and `dbg_data` go to zero, and every indirect entry reads back as 0 afterwards.
- R2: A `host_wr` pulse with `busy` low loads `host_wdata` into the control word, with the status byte (bits 32..39, Verilog `[31:24]`) forced to 0. `busy` is high in the following cycle.
- R3: Every access completes in the cycle after its launch, and `busy` is low again after that edge.
- R4: With command bit `[63]` = 0, completion stores data field `[15:0]` at the entry named by address field `[51:32]`, sets the status byte to 0x82 (bits 32 and 38), and leaves all other bits unchanged.
- R5: With command bit `[63]` = 1, completion replaces `[15:0]` with the addressed entry's contents and sets the status byte to 0x83 (bits 32, 38 and 39). Bits `[63:32]` and `[23:16]` are unchanged.
- R6: An address at or above `ENTRIES` does not alias onto a lower entry. A store to it is dropped, and a fetch from it returns 0.
- R7: At completion, `dbg_addr` takes the access address. `dbg_data` takes the stored data on a store, or the fetched value on a fetch.
- R8: A `host_wr` while `busy` is high is ignored. The word, the store and the debug outputs behave as if it had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | 64 | Control word written by the host |
| host_rdata | output | 64 | Current control word (registered) |
| busy | output | 1 | Access in flight |
| dbg_addr | output | 20 | Address of the last completed access |
| dbg_data | output | 16 | Data moved by the last completed access |

## Verification
Two events can land in the same cycle: the completion of an access and a fresh host write. The second one arrives while `busy` is high. The bench provokes this by writing on the very cycle after a launch, with a different address and data, in both store and fetch modes. The behavioural model discards that write. Any change it makes to the word, the store or the debug outputs therefore shows up as a miscompare on that cycle or in a later fetch. A launch in the first cycle after completion is also exercised, so the boundary between the two cases is checked from both sides.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int WORD_W  = 64;
  localparam int ADDR_W  = 20;
  localparam int DATA_W  = 16;
  localparam int STAT_W  = 8;

  // MSB-first field numbering: field bit k is Verilog bit WORD_W-1-k
  localparam int OP_POS  = WORD_W - 1 - 0;
  localparam int ADDR_HI = WORD_W - 1 - 12;
  localparam int ADDR_LO = WORD_W - 1 - 31;
  localparam int STAT_HI = WORD_W - 1 - 32;
  localparam int STAT_LO = WORD_W - 1 - 39;
  localparam int DATA_HI = WORD_W - 1 - 48;
  localparam int DATA_LO = WORD_W - 1 - 63;

  localparam logic [STAT_W-1:0] ST_STORE_DONE = 8'h82;
  localparam logic [STAT_W-1:0] ST_FETCH_DONE = 8'h83;

  typedef enum logic {OP_STORE = 1'b0, OP_FETCH = 1'b1} ibr_op_e;
endpackage

// File: rtl/ibr_store.sv
module ibr_store #(
  parameter int ENTRIES = 256,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ENTRIES);

  logic [DATA_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_ok_q;

  logic w_in, r_in;
  logic [IDX_W-1:0] widx, ridx;
  assign w_in = ({1'b0, waddr} < LIMIT);
  assign r_in = ({1'b0, raddr} < LIMIT);
  assign widx = waddr[IDX_W-1:0];
  assign ridx = raddr[IDX_W-1:0];

  // data array: no reset, single write port and registered read, RAM friendly
  always_ff @(posedge clk) begin
    if (we && w_in) mem[widx] <= wdata;
    if (re) rd_q <= mem[ridx];
  end

  // valid flags give the cleared-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      rd_ok_q <= 1'b0;
    end else begin
      if (we && w_in) valid_q[widx] <= 1'b1;
      if (re) rd_ok_q <= r_in && valid_q[ridx];
    end
  end

  assign rdata = rd_ok_q ? rd_q : '0;

  assert_oor_fetch_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (re && !r_in) |=> (rdata == '0));
endmodule

// File: rtl/ibr_ctrl.sv
module ibr_ctrl
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] word,
  output logic              busy,
  output logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [WORD_W-1:0] word_q;
  logic              busy_q;
  logic [ADDR_W-1:0] dbg_addr_q;
  logic [DATA_W-1:0] dbg_data_q;

  logic    launch;
  ibr_op_e op;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;

  assign launch   = host_wr && !busy_q;
  assign op       = ibr_op_e'(word_q[OP_POS]);
  assign cur_addr = word_q[ADDR_HI:ADDR_LO];
  assign cur_data = word_q[DATA_HI:DATA_LO];

  assign mem_we    = busy_q && (op == OP_STORE);
  assign mem_waddr = cur_addr;
  assign mem_wdata = cur_data;
  assign mem_re    = launch;
  assign mem_raddr = host_wdata[ADDR_HI:ADDR_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      busy_q     <= 1'b0;
      dbg_addr_q <= '0;
      dbg_data_q <= '0;
    end else if (busy_q) begin
      busy_q     <= 1'b0;
      dbg_addr_q <= cur_addr;
      if (op == OP_FETCH) begin
        word_q[DATA_HI:DATA_LO] <= mem_rdata;
        word_q[STAT_HI:STAT_LO] <= word_q[STAT_HI:STAT_LO] | ST_FETCH_DONE;
        dbg_data_q              <= mem_rdata;
      end else begin
        word_q[STAT_HI:STAT_LO] <= word_q[STAT_HI:STAT_LO] | ST_STORE_DONE;
        dbg_data_q              <= cur_data;
      end
    end else if (launch) begin
      word_q                  <= host_wdata;
      word_q[STAT_HI:STAT_LO] <= '0;
      busy_q                  <= 1'b1;
    end
  end

  assign word     = word_q;
  assign busy     = busy_q;
  assign dbg_addr = dbg_addr_q;
  assign dbg_data = dbg_data_q;

  assert_launch_loads_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy_q && word_q[STAT_HI:STAT_LO] == '0
                && word_q[ADDR_HI:ADDR_LO] == $past(host_wdata[ADDR_HI:ADDR_LO])));
  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q);
  assert_store_status_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !word_q[OP_POS]) |=> (word_q[STAT_HI:STAT_LO] == ST_STORE_DONE
                                     && word_q[DATA_HI:DATA_LO] == $past(word_q[DATA_HI:DATA_LO])));
  assert_fetch_status_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && word_q[OP_POS]) |=> (word_q[STAT_HI:STAT_LO] == ST_FETCH_DONE
                                    && word_q[WORD_W-1:STAT_HI+1] == $past(word_q[WORD_W-1:STAT_HI+1])));
  assert_debug_addr_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (dbg_addr_q == $past(cur_addr)));
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && host_wr) |=> (word_q[ADDR_HI:ADDR_LO] == $past(word_q[ADDR_HI:ADDR_LO])));
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int ENTRIES = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic        busy,
  output logic [19:0] dbg_addr,
  output logic [15:0] dbg_data
);
  import ibr_pkg::*;

  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  ibr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .word       (host_rdata),
    .busy       (busy),
    .dbg_addr   (dbg_addr),
    .dbg_data   (dbg_data),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re),
    .mem_raddr  (mem_raddr),
    .mem_rdata  (mem_rdata)
  );

  ibr_store #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );
endmodule

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;
  localparam int ENTRIES = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        busy;
  logic [19:0] dbg_addr;
  logic [15:0] dbg_data;

  always #10 clk = ~clk;

  ind_reg_bridge #(.ENTRIES(ENTRIES)) u_ind_reg_bridge (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  // behavioural reference state (value after the coming edge)
  logic [63:0] m_word = '0;
  bit          m_busy = 0;
  logic [19:0] m_daddr = '0;
  logic [15:0] m_ddata = '0;
  logic [15:0] m_mem [int];

  int    vectors = 0;
  int    misses  = 0;
  string tag     = "R1";

  function automatic logic [63:0] mk(bit fetch, int addr, logic [15:0] d, logic [7:0] st);
    logic [63:0] w;
    w = {$urandom(), $urandom()};
    w[63] = fetch;
    w[51:32] = 20'(addr);
    w[31:24] = st;
    w[15:0] = d;
    return w;
  endfunction

  task automatic model_edge(bit r, bit wr, logic [63:0] wd);
    int a;
    logic [15:0] v;
    if (r) begin
      m_word = '0; m_busy = 0; m_daddr = '0; m_ddata = '0; m_mem.delete();
    end else if (m_busy) begin
      a = int'(m_word[51:32]);
      m_daddr = m_word[51:32];
      if (m_word[63] == 1'b0) begin
        if (a < ENTRIES) m_mem[a] = m_word[15:0];
        m_word[31:24] = m_word[31:24] | 8'h82;
        m_ddata = m_word[15:0];
      end else begin
        v = (a < ENTRIES && m_mem.exists(a)) ? m_mem[a] : 16'h0;
        m_word[15:0] = v;
        m_word[31:24] = m_word[31:24] | 8'h83;
        m_ddata = v;
      end
      m_busy = 0;
    end else if (wr) begin
      m_word = wd;
      m_word[31:24] = 8'h00;
      m_busy = 1;
    end
  endtask

  task automatic compare();
    vectors++;
    if (host_rdata !== m_word || busy !== m_busy || dbg_addr !== m_daddr || dbg_data !== m_ddata) begin
      misses++;
      $display("FAIL %s: actual word=%h busy=%b dbg=%h/%h expected word=%h busy=%b dbg=%h/%h",
               tag, host_rdata, busy, dbg_addr, dbg_data, m_word, m_busy, m_daddr, m_ddata);
    end
  endtask

  // one clock: check the present state, then drive and predict the next edge
  task automatic step(bit r, bit wr, logic [63:0] wd);
    @(negedge clk);
    compare();
    rst = r; host_wr = wr; host_wdata = wd;
    model_edge(r, wr, wd);
  endtask

  task automatic access(bit fetch, int addr, logic [15:0] d);
    step(0, 1, mk(fetch, addr, d, 8'hFF));
    step(0, 0, '0);
    step(0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    model_edge(1, 0, '0);
    tag = "R1"; repeat (3) step(1, 0, '0);
    step(0, 0, '0);
    tag = "R1"; access(1, 7, 16'h0);               // unwritten entry reads 0
    tag = "R2"; access(0, 5, 16'hBEEF);            // status bits in wdata cleared
    tag = "R4"; access(0, ENTRIES-1, 16'h1357);    // top entry
    tag = "R5"; access(1, 5, 16'h1234);
    tag = "R5"; access(1, ENTRIES-1, 16'hFFFF);
    tag = "R6"; access(0, ENTRIES, 16'hAAAA);      // dropped
    tag = "R6"; access(1, ENTRIES, 16'h5555);
    tag = "R6"; access(1, ENTRIES+5, 16'h0);       // no alias onto entry 5
    tag = "R6"; access(1, 20'hFFFFF, 16'h0);
    tag = "R7"; access(0, 9, 16'h0F0F);
    tag = "R7"; access(1, 9, 16'h0);
    // write arriving in the completion cycle
    tag = "R8";
    step(0, 1, mk(0, 3, 16'hC0DE, 8'h00));
    step(0, 1, mk(0, 4, 16'hDEAD, 8'h00));
    step(0, 0, '0);
    access(1, 4, 16'h0);
    access(1, 3, 16'h0);
    step(0, 1, mk(1, 3, 16'h0, 8'h00));
    step(0, 1, mk(0, 3, 16'h9999, 8'h00));
    step(0, 0, '0);
    access(1, 3, 16'h0);
    // launch right after completion
    tag = "R3";
    step(0, 1, mk(0, 11, 16'h1111, 8'h00));
    step(0, 0, '0);
    step(0, 1, mk(1, 11, 16'h0, 8'h00));
    step(0, 0, '0);
    step(0, 0, '0);
    // reset clears entries
    tag = "R1";
    step(1, 0, '0);
    step(0, 0, '0);
    access(1, 5, 16'h0);
    // random traffic
    tag = "R4";
    for (int i = 0; i < 600; i++) begin
      bit wr_now;
      wr_now = ($urandom_range(0, 2) != 0);
      tag = (i % 2 == 0) ? "R4" : "R5";
      step(0, wr_now, mk($urandom_range(0, 1) == 1, int'($urandom_range(0, ENTRIES + 40)),
                         16'($urandom()), 8'($urandom())));
    end
    step(0, 0, '0);
    step(0, 0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule